// File: doc/BRIEF.md
# Serial/Parallel Fall-Through FIFO

This block is a first-in first-out store of 64 words, each 4 bits wide. A word can enter in two ways. A parallel strobe captures it whole, or it is assembled bit by bit from a serial line that is clocked by its own serial clock. Once the input register holds a complete word, it raises a full flag. A low transfer strobe then moves the word into the top slot of the stack. In the usual hookup the transfer strobe is simply held low, so every completed word goes in as soon as the top slot is free.

Words fall through the stack one slot per system clock, into any empty slot below them, until they reach the output end. The output register takes the oldest word when it is empty and one of its two load requests is high. A parallel load presents the word on a data bus that has a separate drive-enable output; a pop strobe then discards the word. A serial load shifts the word out, least significant bit first, on falling edges of the serial output clock. Both serial clocks are sampled by the system clock, and a high-to-low step between two samples counts as one shift. The system reset and the master-clear input both empty everything.

Top module: `spf_fifo`

## Requirements
- R1: While rst_n or clr_n is low at a clock edge, the block clears in_full, out_ready and every stack slot. No word stored before the clear ever appears at the output.
- R2: When in_full is low, par_load high at a clock edge captures par_din into the input register, and in_full is high after that edge. par_load takes priority over a serial shift in the same cycle.
- R3: When in_full is low, par_load is low and ser_in_en_n is low, each high-to-low step of ser_in_clk (as sampled by clk) shifts ser_din into the word, least significant bit first. After the fourth bit, in_full goes high. Steps seen while ser_in_en_n is high have no effect.
- R4: While in_full is high, par_load and serial steps are ignored, and the waiting word is kept unchanged.
- R5: The waiting word moves into the stack, and in_full falls, only at an edge where xfer_n is low, in_full is high and the top slot is free. While xfer_n stays high, the word waits and nothing reaches the output.
- R6: The stack holds 64 words. With the output idle, a 65th word stays in the input register with in_full high, and a 66th load attempt is lost. On draining, all 65 words come out in the order they were written.
- R7: A word falls one slot per clock into an empty slot below it, so it reaches the output end within 64 cycles. The output register loads the oldest word when it is empty and out_ld_par or out_ld_ser is high, with out_ld_par taking priority. out_ready then goes high.
- R8: out_pop removes a word that was loaded for parallel output. It is ignored when the output register is empty or holds a word loaded for serial output. While a parallel word is held, par_dout does not change.
- R9: For a word loaded through out_ld_ser, ser_dout shows the current bit 0. Each high-to-low step of ser_out_clk while ser_out_en_n is low shifts the word toward bit 0, so bits leave least significant first. out_ready clears after the fourth shift. Steps seen while ser_out_en_n is high are ignored.
- R10: par_drive is high exactly when oe_n is low, and par_dout carries the output register word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low master clear |
| par_load | input | 1 | Parallel capture strobe for the input register |
| par_din | input | 4 | Parallel input word |
| ser_in_clk | input | 1 | Serial input clock; a falling step shifts |
| ser_in_en_n | input | 1 | Active-low serial input enable |
| ser_din | input | 1 | Serial input data |
| xfer_n | input | 1 | Active-low transfer-to-stack strobe |
| in_full | output | 1 | Input register holds a complete word |
| out_ld_par | input | 1 | Request to load the output register for parallel use |
| out_ld_ser | input | 1 | Request to load the output register for serial use |
| out_pop | input | 1 | Discard the parallel word in the output register |
| ser_out_clk | input | 1 | Serial output clock; a falling step shifts |
| ser_out_en_n | input | 1 | Active-low serial output enable |
| oe_n | input | 1 | Active-low parallel output enable |
| out_ready | output | 1 | Output register holds a word |
| ser_dout | output | 1 | Serial output bit (current bit 0) |
| par_dout | output | 4 | Parallel output word |
| par_drive | output | 1 | Drive enable for par_dout |

## Verification
The bench fills the stack while the output side is idle. It checks that the 65th word waits with in_full high and that a 66th is lost; a design that miscounts capacity would either drop a word or let the extra one through. It holds xfer_n high and pops an empty or serial-mode output register. A design that ignored these guards would push a word early, lose a word or corrupt a word. It also pulses both serial clocks while their enables are high and applies a master clear with words in flight. A wrong design would show up as shifted bit order, an early in_full, or a stale word after the clear.

// File: rtl/spf_pkg.sv
// Package spf_pkg
// Shared sizing defaults and the output-register mode type for the
// serial/parallel fall-through FIFO.
package spf_pkg;
    localparam int unsigned SPF_WIDTH = 4;
    localparam int unsigned SPF_DEPTH = 64;

    // How the word in the output register is consumed
    typedef enum logic {
        OUT_MODE_PAR = 1'b0,
        OUT_MODE_SER = 1'b1
    } out_mode_e;
endpackage

// File: rtl/spf_in_reg.sv
// Module spf_in_reg
// Input conversion register. It captures a word in parallel, or assembles
// it LSB first from a serial line whose clock is sampled by clk (a high-to-low
// step between two samples is one shift). It raises full when a word is
// complete and hands the word to the stack when the transfer strobe is low
// and the stack reports its entry slot free.
// Assumes: ser_clk is slow enough that clk sees every level; srst_n is synchronous.
module spf_in_reg #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         srst_n,
    input  logic         par_load,
    input  logic [W-1:0] par_din,
    input  logic         ser_clk,
    input  logic         ser_en_n,
    input  logic         ser_din,
    input  logic         xfer_n,
    input  logic         entry_free,
    output logic         full,
    output logic         push,
    output logic [W-1:0] word
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    logic          sclk_q;
    logic          sclk_fall;
    logic [CW-1:0] bit_cnt;

    // Detect a falling step of the sampled serial clock
    assign sclk_fall = sclk_q & ~ser_clk;
    // Hand the word over when requested, complete and the stack has room
    assign push = full & ~xfer_n & entry_free;

    // Track the previous serial clock level
    always_ff @(posedge clk) begin
        if (!srst_n) sclk_q <= 1'b0;
        else         sclk_q <= ser_clk;
    end

    // Load, shift and hand-over of the input word
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            word    <= '0;
            full    <= 1'b0;
            bit_cnt <= '0;
        end else if (push) begin
            full <= 1'b0;
        end else if (!full) begin
            if (par_load) begin
                word    <= par_din;
                full    <= 1'b1;
                bit_cnt <= '0;
            end else if (!ser_en_n && sclk_fall) begin
                word <= {ser_din, word[W-1:1]};
                if (bit_cnt == LAST_BIT) begin
                    full    <= 1'b1;
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spf_stack.sv
// Module spf_stack
// Fall-through word stack. Slot 0 is the entry end and slot DEPTH-1 is the
// output end. Each slot has a valid bit. A valid word moves one slot per clock
// into an empty slot below it. The entry slot accepts a push only when it is
// empty, and the exit slot is emptied by pop.
// Assumes: push and pop are already qualified by the neighbours.
module spf_stack #(
    parameter int unsigned W     = 4,
    parameter int unsigned DEPTH = 64
) (
    input  logic         clk,
    input  logic         srst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         entry_free,
    output logic         tail_valid,
    output logic [W-1:0] tail_data
);
    localparam int unsigned FLAT = DEPTH * W;

    logic [DEPTH-1:0] valid_vec;
    logic [DEPTH-1:0] move;
    logic [FLAT-1:0]  data_flat;

    assign entry_free = ~valid_vec[0];
    assign tail_valid = valid_vec[DEPTH-1];
    assign tail_data  = data_flat[(DEPTH-1)*W +: W];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic         vq;
        logic [W-1:0] dq;
        logic         take_in;
        logic         give_out;
        logic [W-1:0] src;

        if (i == 0) begin : g_entry
            assign take_in = push & ~vq;
            assign src     = push_data;
        end else begin : g_inner
            assign take_in = move[i-1];
            assign src     = data_flat[(i-1)*W +: W];
        end

        if (i == DEPTH - 1) begin : g_exit
            assign move[i]  = 1'b0;
            assign give_out = pop & vq;
        end else begin : g_fall
            assign move[i]  = vq & ~valid_vec[i+1];
            assign give_out = move[i];
        end

        assign valid_vec[i]          = vq;
        assign data_flat[i*W +: W]   = dq;

        // Slot register: fill from above, empty downward or on pop
        always_ff @(posedge clk) begin
            if (!srst_n) begin
                vq <= 1'b0;
                dq <= '0;
            end else if (take_in) begin
                vq <= 1'b1;
                dq <= src;
            end else if (give_out) begin
                vq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spf_out_reg.sv
// Module spf_out_reg
// Output conversion register. When empty, it takes the exit word of the stack if a
// parallel or serial load request is high, with parallel taking priority.
// A parallel word leaves on pop. A serial word is shifted out LSB first on
// falling steps of the sampled serial output clock, and is gone after W shifts.
// Assumes: ser_clk is slow relative to clk; srst_n is synchronous.
module spf_out_reg
    import spf_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         srst_n,
    input  logic         tail_valid,
    input  logic [W-1:0] tail_data,
    input  logic         ld_par,
    input  logic         ld_ser,
    input  logic         pop,
    input  logic         ser_clk,
    input  logic         ser_en_n,
    output logic         take,
    output logic         valid,
    output out_mode_e    mode,
    output logic [W-1:0] word
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(W - 1);

    logic          sclk_q;
    logic          sclk_fall;
    logic [CW-1:0] bit_cnt;

    assign sclk_fall = sclk_q & ~ser_clk;
    // Pull from the stack only into an empty register on request
    assign take = ~valid & tail_valid & (ld_par | ld_ser);

    // Track the previous serial output clock level
    always_ff @(posedge clk) begin
        if (!srst_n) sclk_q <= 1'b0;
        else         sclk_q <= ser_clk;
    end

    // Load, parallel pop and serial shift of the output word
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            word    <= '0;
            valid   <= 1'b0;
            mode    <= OUT_MODE_PAR;
            bit_cnt <= '0;
        end else if (take) begin
            word    <= tail_data;
            valid   <= 1'b1;
            mode    <= ld_par ? OUT_MODE_PAR : OUT_MODE_SER;
            bit_cnt <= '0;
        end else if (valid && mode == OUT_MODE_PAR) begin
            if (pop) valid <= 1'b0;
        end else if (valid && !ser_en_n && sclk_fall) begin
            word <= {1'b0, word[W-1:1]};
            if (bit_cnt == LAST_BIT) begin
                valid   <= 1'b0;
                bit_cnt <= '0;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spf_fifo.sv
// Module spf_fifo (top)
// Serial/parallel fall-through FIFO of DEPTH words by W bits. It is built from
// an input conversion register, the fall-through stack and an output
// conversion register. The system reset and the master clear are merged into one
// synchronous clear for all three parts.
// Assumes: a single system clock; serial clocks are sampled, not used as clocks.
module spf_fifo
    import spf_pkg::*;
#(
    parameter int unsigned W     = SPF_WIDTH,
    parameter int unsigned DEPTH = SPF_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         par_load,
    input  logic [W-1:0] par_din,
    input  logic         ser_in_clk,
    input  logic         ser_in_en_n,
    input  logic         ser_din,
    input  logic         xfer_n,
    output logic         in_full,
    input  logic         out_ld_par,
    input  logic         out_ld_ser,
    input  logic         out_pop,
    input  logic         ser_out_clk,
    input  logic         ser_out_en_n,
    input  logic         oe_n,
    output logic         out_ready,
    output logic         ser_dout,
    output logic [W-1:0] par_dout,
    output logic         par_drive
);
    logic         srst_n;
    logic         entry_free;
    logic         entry_busy;
    logic         push;
    logic [W-1:0] in_word;
    logic         tail_valid;
    logic [W-1:0] tail_data;
    logic         take;
    out_mode_e    out_mode;
    logic         out_ser_mode;
    logic [W-1:0] out_word;

    // One synchronous clear from either reset source
    assign srst_n       = rst_n & clr_n;
    assign entry_busy   = ~entry_free;
    assign out_ser_mode = (out_mode == OUT_MODE_SER);
    assign par_dout     = out_word;
    assign ser_dout     = out_word[0];
    assign par_drive    = ~oe_n;

    spf_in_reg #(.W(W)) u_in (
        .clk        (clk),
        .srst_n     (srst_n),
        .par_load   (par_load),
        .par_din    (par_din),
        .ser_clk    (ser_in_clk),
        .ser_en_n   (ser_in_en_n),
        .ser_din    (ser_din),
        .xfer_n     (xfer_n),
        .entry_free (entry_free),
        .full       (in_full),
        .push       (push),
        .word       (in_word)
    );

    spf_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .srst_n     (srst_n),
        .push       (push),
        .push_data  (in_word),
        .pop        (take),
        .entry_free (entry_free),
        .tail_valid (tail_valid),
        .tail_data  (tail_data)
    );

    spf_out_reg #(.W(W)) u_out (
        .clk        (clk),
        .srst_n     (srst_n),
        .tail_valid (tail_valid),
        .tail_data  (tail_data),
        .ld_par     (out_ld_par),
        .ld_ser     (out_ld_ser),
        .pop        (out_pop),
        .ser_clk    (ser_out_clk),
        .ser_en_n   (ser_out_en_n),
        .take       (take),
        .valid      (out_ready),
        .mode       (out_mode),
        .word       (out_word)
    );
endmodule

// File: rtl/spf_fifo_chk.sv
// Module spf_fifo_chk
// Property checker for spf_fifo, attached with the bind below. It observes
// the handshake flags, the transfer strobe and the output word over time.
module spf_fifo_chk #(
    parameter int unsigned W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_n,
    input logic         xfer_n,
    input logic         in_full,
    input logic         entry_busy,
    input logic         out_ready,
    input logic         out_pop,
    input logic         ld_par,
    input logic         ld_ser,
    input logic         ser_mode,
    input logic [W-1:0] par_dout
);
    // R5: a complete word stays put while the transfer is held off or blocked
    assert_word_waits_R5: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        in_full && (xfer_n || entry_busy) |=> in_full);

    // R5: in_full only falls after a low transfer strobe or a clear
    assert_fall_needs_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_full) |-> ($past(!xfer_n) || $past(!clr_n)));

    // R8: an empty output register stays empty without a load request
    assert_empty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !out_ready && !ld_par && !ld_ser |=> !out_ready);

    // R8: a parallel word is held steady until popped
    assert_par_word_stable_R8: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        out_ready && !ser_mode && !out_pop |=> out_ready && $stable(par_dout));

    // R1: master clear empties both registers
    assert_clear_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> !in_full && !out_ready);
endmodule

bind spf_fifo spf_fifo_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_n      (clr_n),
    .xfer_n     (xfer_n),
    .in_full    (in_full),
    .entry_busy (entry_busy),
    .out_ready  (out_ready),
    .out_pop    (out_pop),
    .ld_par     (out_ld_par),
    .ld_ser     (out_ld_ser),
    .ser_mode   (out_ser_mode),
    .par_dout   (par_dout)
);

// File: tb/sim_spf_fifo.sv
`timescale 1ns/1ps
module sim_spf_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_n = 1'b1;
    logic       par_load = 1'b0;
    logic [3:0] par_din = '0;
    logic       ser_in_clk = 1'b0;
    logic       ser_in_en_n = 1'b0;
    logic       ser_din = 1'b0;
    logic       xfer_n = 1'b0;
    logic       in_full;
    logic       out_ld_par = 1'b0;
    logic       out_ld_ser = 1'b0;
    logic       out_pop = 1'b0;
    logic       ser_out_clk = 1'b0;
    logic       ser_out_en_n = 1'b0;
    logic       oe_n = 1'b1;
    logic       out_ready;
    logic       ser_dout;
    logic [3:0] par_dout;
    logic       par_drive;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    spf_fifo u0 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .par_load(par_load),
        .par_din(par_din), .ser_in_clk(ser_in_clk), .ser_in_en_n(ser_in_en_n),
        .ser_din(ser_din), .xfer_n(xfer_n), .in_full(in_full),
        .out_ld_par(out_ld_par), .out_ld_ser(out_ld_ser), .out_pop(out_pop),
        .ser_out_clk(ser_out_clk), .ser_out_en_n(ser_out_en_n), .oe_n(oe_n),
        .out_ready(out_ready), .ser_dout(ser_dout), .par_dout(par_dout),
        .par_drive(par_drive)
    );

    // Vector: [5] serial input, [4] serial output, [3:0] word
    localparam logic [5:0] VEC [8] = '{
        6'b00_0101, 6'b10_1010, 6'b01_0011, 6'b11_1100,
        6'b00_1111, 6'b10_0001, 6'b01_1000, 6'b11_0110
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_par(input logic [3:0] d);
        for (int i = 0; i < 200 && in_full; i++) @(negedge clk);
        par_din = d; par_load = 1'b1;
        @(negedge clk); par_load = 1'b0;
    endtask

    task automatic wr_ser(input logic [3:0] d);
        for (int i = 0; i < 200 && in_full; i++) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
            ser_din = d[b]; ser_in_clk = 1'b1;
            @(negedge clk); ser_in_clk = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic wait_ready(output bit got);
        got = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (out_ready) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic rd_par(output logic [3:0] d, output bit got);
        wait_ready(got);
        d = par_dout;
        if (got) begin
            out_pop = 1'b1; @(negedge clk); out_pop = 1'b0;
        end
    endtask

    task automatic rd_ser(output logic [3:0] d, output bit got);
        wait_ready(got);
        d = '0;
        for (int b = 0; b < 4; b++) begin
            d[b] = ser_dout;
            ser_out_clk = 1'b1; @(negedge clk); ser_out_clk = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] d;
        bit got;
        cyc(3);
        // R1: reset state
        check(in_full == 1'b0, "R1 in_full after reset", in_full, 0);
        check(out_ready == 1'b0, "R1 out_ready after reset", out_ready, 0);
        rst_n = 1'b1;
        cyc(2);
        // R10: drive enable follows oe_n
        check(par_drive == 1'b0, "R10 drive off", par_drive, 0);
        oe_n = 1'b0; cyc(1);
        check(par_drive == 1'b1, "R10 drive on", par_drive, 1);

        // Table walk: R2 R3 R7 R8 R9
        foreach (VEC[k]) begin
            out_ld_par = ~VEC[k][4];
            out_ld_ser = VEC[k][4];
            if (VEC[k][5]) wr_ser(VEC[k][3:0]); else wr_par(VEC[k][3:0]);
            if (VEC[k][4]) rd_ser(d, got); else rd_par(d, got);
            check(got, "R7 word reaches output", got, 1);
            check(d == VEC[k][3:0], VEC[k][4] ? "R9 serial out LSB first" : "R2 R3 R8 data",
                  d, VEC[k][3:0]);
            cyc(1);
            check(out_ready == 1'b0, "R8 R9 word consumed", out_ready, 0);
        end

        // R3: serial steps ignored while disabled
        out_ld_par = 1'b1; out_ld_ser = 1'b0;
        ser_in_en_n = 1'b1;
        wr_ser(4'b1111);
        check(in_full == 1'b0, "R3 disabled serial ignored", in_full, 0);
        ser_in_en_n = 1'b0;
        wr_ser(4'b1001);
        rd_par(d, got);
        check(d == 4'b1001, "R3 no stale bits", d, 4'b1001);

        // R5: word waits while xfer_n high
        xfer_n = 1'b1;
        wr_par(4'h5);
        cyc(80);
        check(in_full == 1'b1, "R5 word waits", in_full, 1);
        check(out_ready == 1'b0, "R5 nothing transferred", out_ready, 0);
        // R4: load while full ignored
        wr_par(4'hE);
        xfer_n = 1'b0;
        rd_par(d, got);
        check(d == 4'h5, "R4 waiting word kept", d, 5);
        cyc(80);
        check(out_ready == 1'b0, "R4 extra load lost", out_ready, 0);

        // R8: pop on empty ignored, pop on serial word ignored
        out_ld_par = 1'b0;
        out_pop = 1'b1; cyc(1); out_pop = 1'b0; cyc(1);
        check(out_ready == 1'b0, "R8 pop on empty", out_ready, 0);
        out_ld_ser = 1'b1;
        wr_par(4'hC);
        wait_ready(got);
        out_ld_ser = 1'b0;
        out_pop = 1'b1; cyc(1); out_pop = 1'b0; cyc(1);
        check(out_ready == 1'b1, "R8 pop on serial word ignored", out_ready, 1);
        // R9: serial output clock ignored while disabled
        ser_out_en_n = 1'b1;
        ser_out_clk = 1'b1; cyc(1); ser_out_clk = 1'b0; cyc(1);
        check(ser_dout == 1'b0, "R9 disabled shift ignored", ser_dout, 0);
        ser_out_en_n = 1'b0;
        rd_ser(d, got);
        check(d == 4'hC, "R9 serial word intact", d, 4'hC);

        // R7: parallel load request wins over serial
        out_ld_par = 1'b1; out_ld_ser = 1'b1;
        wr_par(4'h9);
        rd_par(d, got);
        cyc(1);
        check(d == 4'h9 && out_ready == 1'b0, "R7 parallel priority", d, 9);
        out_ld_par = 1'b0; out_ld_ser = 1'b0;

        // R1: master clear with words in flight
        wr_par(4'h3); wr_par(4'h4); wr_par(4'h6);
        clr_n = 1'b0; cyc(1); clr_n = 1'b1;
        check(in_full == 1'b0, "R1 clear in_full", in_full, 0);
        out_ld_par = 1'b1;
        cyc(80);
        check(out_ready == 1'b0, "R1 clear empties stack", out_ready, 0);
        out_ld_par = 1'b0;

        // R6: capacity and order
        for (int k = 0; k < 65; k++) wr_par(4'(k));
        cyc(20);
        check(in_full == 1'b1, "R6 65th word waits", in_full, 1);
        wr_par(4'hF);
        out_ld_par = 1'b1;
        for (int k = 0; k < 65; k++) begin
            rd_par(d, got);
            check(got && d == 4'(k), "R6 drain order", d, k % 16);
        end
        cyc(80);
        check(out_ready == 1'b0, "R6 66th word lost", out_ready, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule